// File: doc/BRIEF.md
# Programmable Down-Counting Timer with APB Register Access

This block is a single 32-bit timer channel that software drives over an APB slave port. Once enabled, the counter starts from a programmed start value and counts down by one every clock cycle. When it has reached zero it flags an event, sets a sticky status bit and drives an interrupt line unless the interrupt is masked. It then starts the next round. In periodic mode the next round starts again from the programmed value. In free-running mode it starts from the all-ones maximum, which lets software use the counter as a wide timebase by inverting the live count.

To program the timer, software clears the enable bit, writes the start value and then sets the enable bit again. The start value is taken into the counter on the cycle after enable rises. To acknowledge an interrupt, software simply reads one of the two acknowledge addresses; no write is needed. The counter runs on the bus clock, and one clock cycle counts as one timer tick. The bus never inserts wait states and never reports an error.

Top module: `apb_dtimer`

## Requirements
- R1: After reset the start-value register, control register and live count all read as zero, and `irq` is low.
- R2: Register offsets are start value 0x00 (read/write), live count 0x04 (read only) and control 0x08 (read/write). Control bit 0 is enable, bit 1 is mode (1 = periodic, 0 = free-running) and bit 2 is the interrupt mask (1 = suppress). Control bits above bit 2 read as zero.
- R3: While enable is 0, the live count holds its value and no new zero event occurs.
- R4: On the cycle after enable goes from 0 to 1, the count takes the start value. After that it decreases by one on every cycle.
- R5: In periodic mode, one cycle after the count has reached zero, it reloads the start value and the raw status sets. With start value L, zero events therefore occur every L+1 cycles.
- R6: In free-running mode, the count reloads 0xFFFF_FFFF after reaching zero instead of the start value.
- R7: The raw status bit (read at 0xA8, bit 0) sets on every zero event whatever the mask. The masked status (0x10 and 0xA0, bit 0) and `irq` follow the raw status only while the mask bit is 0.
- R8: A completed read of 0x0C or of 0xA4 clears the raw status on the access edge and returns zero.
- R9: If a zero event and an acknowledge read fall on the same clock edge, the event wins and the status stays set.
- R10: `pready` is always 1 and `pslverr` is always 0. An access completes in the cycle that `penable` is high, and unmapped addresses read as zero.
- R11: Offset 0xAC reads a fixed version constant given by a parameter (default 0x0001_0200).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always no error |
| irq | output | 1 | Masked timer interrupt |

## Verification
On every cycle, the assertions check the counter's step rules: it holds while disabled, takes the start value after enable rises, decrements while running, and reloads either the start value or all ones at zero. They also check that a zero event always leaves the status set, that an acknowledge read with no event present clears it, that a set mask keeps `irq` low, and that the bus handshake constants hold. Only the bench scenarios show the cycle-exact interrupt timing for a given start value, the counts read back over the bus, the readback of the registers and the version constant, and the ordering of the acknowledge read against a zero event on the same edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_START    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ACK      = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SYS_STAT = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_SYS_ACK  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_SYS_RAW  = 8'hA8;
    localparam logic [ADDR_W-1:0] OFS_VERSION  = 8'hAC;

    // packed: enable lands on bit 0, periodic on bit 1, mask on bit 2
    typedef struct packed {
        logic mask;
        logic periodic;
        logic enable;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef enum logic [3:0] {
        SEL_START,
        SEL_COUNT,
        SEL_CTRL,
        SEL_ACK,
        SEL_STAT,
        SEL_SYS_STAT,
        SEL_SYS_ACK,
        SEL_SYS_RAW,
        SEL_VERSION,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_START:    s = SEL_START;
            OFS_COUNT:    s = SEL_COUNT;
            OFS_CTRL:     s = SEL_CTRL;
            OFS_ACK:      s = SEL_ACK;
            OFS_STAT:     s = SEL_STAT;
            OFS_SYS_STAT: s = SEL_SYS_STAT;
            OFS_SYS_ACK:  s = SEL_SYS_ACK;
            OFS_SYS_RAW:  s = SEL_SYS_RAW;
            OFS_VERSION:  s = SEL_VERSION;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_ack_sel(input reg_sel_e s);
        return (s == SEL_ACK) || (s == SEL_SYS_ACK);
    endfunction

endpackage

// File: rtl/dtmr_apb_regs.sv
module dtmr_apb_regs
    import dtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              raw_st,
    input  logic              masked_st,
    output logic [DATA_W-1:0] prdata,
    output logic [CNT_W-1:0]  start_q,
    output ctrl_t             ctrl_q,
    output logic              ack_pulse
);

    reg_sel_e sel;
    logic     wr_en;
    logic     rd_done;

    assign sel     = decode_addr(paddr);
    assign wr_en   = psel && penable && pwrite;
    assign rd_done = psel && penable && !pwrite;

    assign ack_pulse = rd_done && is_ack_sel(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_START) start_q <= pwdata[CNT_W-1:0];
            if (sel == SEL_CTRL)  ctrl_q  <= ctrl_t'(pwdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_START:    prdata = DATA_W'(start_q);
                SEL_COUNT:    prdata = DATA_W'(count);
                SEL_CTRL:     prdata = DATA_W'(ctrl_q);
                SEL_STAT:     prdata = DATA_W'(masked_st);
                SEL_SYS_STAT: prdata = DATA_W'(masked_st);
                SEL_SYS_RAW:  prdata = DATA_W'(raw_st);
                SEL_VERSION:  prdata = VERSION;
                default:      prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             run_d,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             first_tick;
    logic [CNT_W-1:0] reload_val;

    assign first_tick = ctrl.enable && !run_d;
    assign zero_evt   = ctrl.enable && run_d && (count == '0);
    assign reload_val = ctrl.periodic ? start_val : CNT_MAX;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run_d <= 1'b0;
        end else begin
            run_d <= ctrl.enable;
            if (first_tick) begin
                count <= start_val;
            end else if (zero_evt) begin
                count <= reload_val;
            end else if (ctrl.enable) begin
                count <= count - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtmr_irq_stat.sv
module dtmr_irq_stat (
    input  logic clk,
    input  logic rst,
    input  logic zero_evt,
    input  logic ack,
    input  logic mask,
    output logic raw_st,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_st <= 1'b0;
        end else if (zero_evt) begin
            raw_st <= 1'b1;
        end else if (ack) begin
            raw_st <= 1'b0;
        end
    end

    assign irq = raw_st && !mask;

endmodule

// File: rtl/apb_dtimer.sv
module apb_dtimer
    import dtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] count;
    logic             run_d;
    logic             zero_evt;
    logic             ack_pulse;
    logic             raw_st;
    logic             irq_int;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq     = irq_int;

    dtmr_apb_regs #(.CNT_W(CNT_W), .VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .count     (count),
        .raw_st    (raw_st),
        .masked_st (irq_int),
        .prdata    (prdata),
        .start_q   (start_q),
        .ctrl_q    (ctrl_q),
        .ack_pulse (ack_pulse)
    );

    dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .start_val (start_q),
        .count     (count),
        .run_d     (run_d),
        .zero_evt  (zero_evt)
    );

    dtmr_irq_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .zero_evt (zero_evt),
        .ack      (ack_pulse),
        .mask     (ctrl_q.mask),
        .raw_st   (raw_st),
        .irq      (irq_int)
    );

endmodule

// File: rtl/apb_dtimer_chk.sv
module apb_dtimer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [7:0]       paddr,
    input logic             pready,
    input logic             pslverr,
    input logic             irq,
    input logic             ctrl_en,
    input logic             ctrl_periodic,
    input logic             ctrl_mask,
    input logic             run_d,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] start_q,
    input logic             raw_st
);

    logic at_zero;
    logic ack_rd;

    assign at_zero = ctrl_en && run_d && (count == '0);
    assign ack_rd  = psel && penable && !pwrite && (paddr == 8'h0C || paddr == 8'hA4);

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> $stable(count));

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !run_d) |=> (count == $past(start_q)));

    // R4
    decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && run_d && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (at_zero && ctrl_periodic) |=> (count == $past(start_q)));

    // R6
    freerun_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !ctrl_periodic) |=> (count == '1));

    // R9
    event_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        at_zero |=> raw_st);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !at_zero) |=> !raw_st);

    // R7
    mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_mask |-> !irq);

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(raw_st) || $fell(ctrl_mask)));

    // R10
    bus_const_chk: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

endmodule

bind apb_dtimer apb_dtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .psel          (psel),
    .penable       (penable),
    .pwrite        (pwrite),
    .paddr         (paddr),
    .pready        (pready),
    .pslverr       (pslverr),
    .irq           (irq),
    .ctrl_en       (ctrl_q.enable),
    .ctrl_periodic (ctrl_q.periodic),
    .ctrl_mask     (ctrl_q.mask),
    .run_d         (run_d),
    .count         (count),
    .start_q       (start_q),
    .raw_st        (raw_st)
);

// File: tb/apb_dtimer_test.sv
module apb_dtimer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    apb_dtimer uut (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // starts and ends on a falling edge; write lands on the second rising edge
    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // data sampled one falling edge after setup; side effect on the next rising edge
    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        checks++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            failures++;
            $display("FAIL R10 actual=%b%b expected=10", pready, pslverr);
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq", 32'(irq), 32'h0);
        apb_rd(8'h00, d); check("R1 start", d, 32'h0);
        apb_rd(8'h08, d); check("R1 ctrl", d, 32'h0);
        apb_rd(8'h04, d); check("R1 count", d, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        apb_wr(8'h00, 32'hDEAD_BEEF);
        apb_rd(8'h00, d); check("R2 start readback", d, 32'hDEAD_BEEF);
        apb_wr(8'h08, 32'hFFFF_FFFA);
        apb_rd(8'h08, d); check("R2 ctrl readback", d, 32'h2);
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h50, d); check("R10 unmapped", d, 32'h0);
        apb_rd(8'hFC, d); check("R10 unmapped high", d, 32'h0);
        apb_rd(8'hAC, d); check("R11 version", d, 32'h0001_0200);
    endtask

    task automatic t_start_dec;
        logic [31:0] d;
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h00, 32'd10);
        apb_wr(8'h08, 32'h3);
        apb_rd(8'h04, d); check("R4 first tick", d, 32'd10);
        apb_rd(8'h04, d); check("R4 decrement", d, 32'd8);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h0C, d);
        apb_wr(8'h00, 32'd3);
        apb_wr(8'h08, 32'h3);
        repeat (4) @(negedge clk);
        check("R5 no irq before zero", 32'(irq), 32'h0);
        @(negedge clk);
        check("R5 irq at zero", 32'(irq), 32'h1);
        apb_rd(8'h04, d); check("R5 reload start", d, 32'd2);
    endtask

    task automatic t_freerun;
        logic [31:0] d;
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h0C, d);
        check("R8 ack clears", 32'(irq), 32'h0);
        apb_wr(8'h00, 32'd2);
        apb_wr(8'h08, 32'h1);
        repeat (4) @(negedge clk);
        apb_rd(8'h04, d); check("R6 reload all ones", d, 32'hFFFF_FFFE);
        apb_rd(8'hA8, d); check("R7 raw after freerun", d, 32'h1);
    endtask

    task automatic t_hold;
        logic [31:0] a;
        logic [31:0] b;
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h0C, a);
        check("R8 ack reads zero", a, 32'h0);
        apb_rd(8'h04, a);
        repeat (20) @(negedge clk);
        apb_rd(8'h04, b); check("R3 hold", b, a);
        apb_rd(8'hA8, b); check("R3 no event", b, 32'h0);
        check("R3 irq low", 32'(irq), 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h0C, d);
        apb_wr(8'h00, 32'd3);
        apb_wr(8'h08, 32'h3);
        repeat (5) @(negedge clk);
        apb_rd(8'h0C, d);
        check("R8 ack between events", 32'(irq), 32'h0);
        apb_rd(8'h0C, d);
        check("R9 event wins over ack", 32'(irq), 32'h1);
        apb_rd(8'h0C, d);
        check("R8 ack after event", 32'(irq), 32'h0);
        repeat (2) @(negedge clk);
        check("R5 next period", 32'(irq), 32'h1);
        apb_rd(8'hA4, d);
        check("R8 system ack clears", 32'(irq), 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h0C, d);
        apb_wr(8'h08, 32'h7);
        repeat (10) @(negedge clk);
        check("R7 masked irq", 32'(irq), 32'h0);
        apb_rd(8'hA8, d); check("R7 raw set under mask", d, 32'h1);
        apb_rd(8'h10, d); check("R7 channel status masked", d, 32'h0);
        apb_rd(8'hA0, d); check("R7 system status masked", d, 32'h0);
        apb_wr(8'h08, 32'h3);
        check("R7 unmask shows irq", 32'(irq), 32'h1);
        apb_rd(8'h10, d); check("R7 channel status unmasked", d, 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_start_dec;
        t_periodic;
        t_freerun;
        t_hold;
        t_collide;
        t_mask;
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule